// File: doc/BRIEF.md
# Maskable Sticky Error Logging Unit

This block gathers single-cycle error pulses from one interface unit and records each one in a unit status register. Every status bit stays set until software writes a 1 to it. A mask register then decides, for each error, whether it also travels on to two local logs and to a global summary line. The first log, called the first-error register, takes the first unmasked error that arrives while it is empty. The second log, called the next-error register, collects the unmasked errors that come later. The summary output stays high for as long as the first-error register holds any bit.

Software reads and writes all four registers through one register port. The port has a write strobe, a 2-bit address, write data and combinational read data. Two resets apply. A cold reset clears every register and reloads the mask default. A warm reset clears only the first-error and next-error logs. The status and mask registers keep their contents through a warm reset.

Error positions in the 32-bit vectors:
- Bit 0: lost SMBus arbitration.
- Bit 1: unexpected SMBus NAK.
- Bit 2: SMBus clock held low for more than 25 ms.
- Bit 5: flow-control DLLP timeout.
- Bit 12: link-layer protocol error.
- Bits 13 to 15: upstream completion, non-posted and posted queue overflow.

All other positions are reserved.

Capture control is a two-state machine, FE_EMPTY and FE_HELD, with these transitions:
- capture (FE_EMPTY to FE_HELD): at least one unmasked error arrives.
- release (FE_HELD to FE_EMPTY): a software clear removes every remaining first-error bit.
- reset (any state to FE_EMPTY): a cold or warm reset.

While in FE_HELD, unmasked errors are sent to the next-error register.

Top module: `errlog_unit`

## Requirements
- R1: After a cold reset, the registers read as follows: status (address 0) is 0, first-error (address 2) is 0, next-error (address 3) is 0, mask (address 1) is 0x0000E000, and global_err is 0.
- R2: A pulse on err_pulse bit 0, 1, 2, 5, 12, 13, 14 or 15 sets the same status bit at the next clock edge, whether or not it is masked. Pulses on any other bit never set anything.
- R3: Writing to status clears each bit where the write data holds a 1 and leaves each bit where the data holds a 0.
- R4: If an error pulse and a write-1 clear hit the same status or next-error bit in the same cycle, the bit ends up set.
- R5: Mask bits 15:0 are read/write. Mask bits 31:16 read as 0 whatever is written.
- R6: An error whose mask bit (in 15:4) is 1 never reaches the first-error register, the next-error register or global_err.
- R7: Mask bits 3:0 have no effect: errors on bits 0 to 2 propagate even when those mask bits are 1.
- R8: While first-error is 0, all unmasked errors arriving in one cycle are loaded into first-error together. Writing a 1 to first-error clears that bit.
- R9: While first-error is non-zero, it holds its value. Further unmasked errors set next-error bits instead. Writing a 1 to next-error clears that bit.
- R10: global_err is 1 from the edge that loads first-error until the edge that clears its last bit.
- R11: A warm reset clears first-error, next-error and global_err, and leaves status and mask unchanged.

| Port | Direction | Width | Description |
|---|---|---|---|

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Synchronous active-low cold reset |
| warm_rst_n | input | 1 | Synchronous active-low warm reset |
| err_pulse | input | 32 | One-cycle error event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 status, 1 mask, 2 first-error, 3 next-error |
| reg_wdata | input | 32 | Write data; a 1 clears the bit for addresses 0, 2 and 3 |
| reg_rdata | output | 32 | Read data for reg_addr |
| global_err | output | 1 | Global error summary |

## Verification
The bench builds the block with its default parameters: a 32-bit width, the eight valid positions, a mask default of 0x0000E000 and an ignored low nibble. With these values, a single stimulus run can reach the reserved status positions, the reserved upper mask half, the default-masked overflow bits and the unmaskable SMBus bits. A vector table runs a cumulative sequence of events through the status, first-error and next-error registers. Directed tests then cover clears that collide with new events, partial clears of the first-error register, the warm reset and a second cold reset.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_MASK   = 2'd1,
        RA_FIRST  = 2'd2,
        RA_NEXT   = 2'd3
    } reg_addr_e;

    typedef enum logic {
        FE_EMPTY = 1'b0,
        FE_HELD  = 1'b1
    } first_state_e;

endpackage

// File: rtl/errlog_w1c_bank.sv
module errlog_w1c_bank #(
    parameter int          W           = 32,
    parameter logic [W-1:0] VALID      = '1,
    parameter bit          WARM_CLEARS = 1'b0
) (
    input  logic         clk,
    input  logic         cold_rst_n,
    input  logic         warm_rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    logic         rst_hit;
    logic [W-1:0] q;

    generate
        if (WARM_CLEARS) begin : g_warm
            assign rst_hit = !cold_rst_n || !warm_rst_n;
        end else begin : g_sticky
            assign rst_hit = !cold_rst_n;
        end
    endgenerate

    // set has priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst_hit) q <= '0;
        else         q <= ((q & ~clr_i) | set_i) & VALID;
    end

    assign q_o = q;

endmodule

// File: rtl/errlog_mask_reg.sv
module errlog_mask_reg #(
    parameter int           W         = 32,
    parameter logic [W-1:0] RESET_VAL = '0,
    parameter logic [W-1:0] WRITABLE  = '1
) (
    input  logic         clk,
    input  logic         cold_rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (!cold_rst_n) q <= RESET_VAL & WRITABLE;
        else if (wr_i)   q <= wdata_i & WRITABLE;
    end

    assign q_o = q;

endmodule

// File: rtl/errlog_first_fsm.sv
module errlog_first_fsm
    import errlog_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         cold_rst_n,
    input  logic         warm_rst_n,
    input  logic [W-1:0] unmasked_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] first_o,
    output logic [W-1:0] to_next_o,
    output logic         held_o
);

    first_state_e state_q, state_d;
    logic [W-1:0] first_q, first_d;
    logic         rst_hit;

    assign rst_hit = !cold_rst_n || !warm_rst_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst_hit) state_q <= FE_EMPTY;
        else         state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        first_d   = first_q;
        to_next_o = '0;
        unique case (state_q)
            FE_EMPTY: begin
                if (unmasked_i != '0) begin
                    first_d = unmasked_i;   // capture
                    state_d = FE_HELD;
                end
            end
            FE_HELD: begin
                to_next_o = unmasked_i;
                first_d   = first_q & ~clr_i;
                if (first_d == '0) state_d = FE_EMPTY;   // release
            end
            default: state_d = FE_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_hit) first_q <= '0;
        else         first_q <= first_d;
    end

    assign first_o = first_q;
    assign held_o  = (state_q == FE_HELD);

endmodule

// File: rtl/errlog_unit.sv
module errlog_unit
    import errlog_pkg::*;
#(
    parameter int              ERR_W       = 32,
    parameter logic [ERR_W-1:0] VALID_BITS = 32'h0000_F027,
    parameter logic [ERR_W-1:0] MASK_RESET = 32'h0000_E000,
    parameter logic [ERR_W-1:0] MASK_RW    = 32'h0000_FFFF,
    parameter logic [ERR_W-1:0] IGNORE_BITS = 32'h0000_000F
) (
    input  logic             clk,
    input  logic             cold_rst_n,
    input  logic             warm_rst_n,
    input  logic [ERR_W-1:0] err_pulse,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [ERR_W-1:0] reg_wdata,
    output logic [ERR_W-1:0] reg_rdata,
    output logic             global_err
);

    localparam logic [ERR_W-1:0] GATE_BITS = ~IGNORE_BITS;

    reg_addr_e        addr;
    logic [ERR_W-1:0] status_q, mask_q, first_q, next_q;
    logic [ERR_W-1:0] valid_ev, unmasked, to_next;
    logic [ERR_W-1:0] clr_status, clr_first, clr_next;
    logic             wr_mask, held;

    assign addr       = reg_addr_e'(reg_addr);
    assign valid_ev   = err_pulse & VALID_BITS;
    assign unmasked   = valid_ev & ~(mask_q & GATE_BITS);
    assign wr_mask    = reg_wr && (addr == RA_MASK);
    assign clr_status = (reg_wr && addr == RA_STATUS) ? reg_wdata : '0;
    assign clr_first  = (reg_wr && addr == RA_FIRST)  ? reg_wdata : '0;
    assign clr_next   = (reg_wr && addr == RA_NEXT)   ? reg_wdata : '0;

    errlog_w1c_bank #(.W(ERR_W), .VALID(VALID_BITS), .WARM_CLEARS(1'b0)) u_status (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .set_i(valid_ev), .clr_i(clr_status), .q_o(status_q)
    );

    errlog_mask_reg #(.W(ERR_W), .RESET_VAL(MASK_RESET), .WRITABLE(MASK_RW)) u_mask (
        .clk(clk), .cold_rst_n(cold_rst_n), .wr_i(wr_mask),
        .wdata_i(reg_wdata), .q_o(mask_q)
    );

    errlog_first_fsm #(.W(ERR_W)) u_first (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .unmasked_i(unmasked), .clr_i(clr_first),
        .first_o(first_q), .to_next_o(to_next), .held_o(held)
    );

    errlog_w1c_bank #(.W(ERR_W), .VALID(VALID_BITS), .WARM_CLEARS(1'b1)) u_next (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .set_i(to_next), .clr_i(clr_next), .q_o(next_q)
    );

    always_comb begin
        unique case (addr)
            RA_STATUS: reg_rdata = status_q;
            RA_MASK:   reg_rdata = mask_q;
            RA_FIRST:  reg_rdata = first_q;
            RA_NEXT:   reg_rdata = next_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign global_err = held;

endmodule

// File: rtl/errlog_unit_chk.sv
module errlog_unit_chk #(
    parameter int               ERR_W       = 32,
    parameter logic [ERR_W-1:0] VALID_BITS  = 32'h0000_F027,
    parameter logic [ERR_W-1:0] IGNORE_BITS = 32'h0000_000F
) (
    input logic             clk,
    input logic             cold_rst_n,
    input logic             warm_rst_n,
    input logic [ERR_W-1:0] err_pulse,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [ERR_W-1:0] reg_wdata,
    input logic             global_err,
    input logic [ERR_W-1:0] status_q,
    input logic [ERR_W-1:0] mask_q,
    input logic [ERR_W-1:0] first_q
);

    logic [ERR_W-1:0] live;
    assign live = err_pulse & VALID_BITS & ~(mask_q & ~IGNORE_BITS);

    a_r2_status_records: assert property (@(posedge clk) disable iff (!cold_rst_n)
        ((err_pulse & VALID_BITS) != '0) |=>
        ((status_q & $past(err_pulse & VALID_BITS)) == $past(err_pulse & VALID_BITS)));

    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (reg_wr && reg_addr == 2'd0) |=>
        ((status_q & $past(reg_wdata & ~err_pulse)) == '0));

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (reg_wr && reg_addr == 2'd0) |=>
        ((status_q & $past(reg_wdata & err_pulse & VALID_BITS))
            == $past(reg_wdata & err_pulse & VALID_BITS)));

    a_r6_masked_no_capture: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        (first_q == '0 && live == '0) |=> (first_q == '0));

    a_r9_first_holds: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        (first_q != '0 && !(reg_wr && reg_addr == 2'd2)) |=> $stable(first_q));

    a_r10_global_tracks: assert property (@(posedge clk) disable iff (!cold_rst_n)
        global_err == (first_q != '0));

    a_r11_warm_keeps: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (!warm_rst_n && !reg_wr) |=>
        (((status_q & $past(status_q)) == $past(status_q)) && $stable(mask_q)));

endmodule

bind errlog_unit errlog_unit_chk #(
    .ERR_W(ERR_W), .VALID_BITS(VALID_BITS), .IGNORE_BITS(IGNORE_BITS)
) u_chk (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .err_pulse(err_pulse), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .global_err(global_err),
    .status_q(status_q), .mask_q(mask_q), .first_q(first_q)
);

// File: tb/tb_errlog_unit.sv
`timescale 1ns/1ps
module tb_errlog_unit;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic [31:0] err_pulse = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        global_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    errlog_unit dut (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .err_pulse(err_pulse), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .global_err(global_err)
    );

    // {event, status, first, next}; starts from cold reset, mask 0x0000E000
    localparam logic [127:0] TBL [7] = '{
        {32'h0000_0002, 32'h0000_0002, 32'h0000_0002, 32'h0000_0000},
        {32'h0000_2000, 32'h0000_2002, 32'h0000_0002, 32'h0000_0000},
        {32'h0000_1000, 32'h0000_3002, 32'h0000_0002, 32'h0000_1000},
        {32'h0000_0018, 32'h0000_3002, 32'h0000_0002, 32'h0000_1000},
        {32'h0000_0021, 32'h0000_3023, 32'h0000_0002, 32'h0000_1021},
        {32'h0000_00C0, 32'h0000_3023, 32'h0000_0002, 32'h0000_1021},
        {32'h0000_C000, 32'h0000_F023, 32'h0000_0002, 32'h0000_1021}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr_ev(input logic [1:0] a, input logic [31:0] d, input logic [31:0] e);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; err_pulse = e;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; err_pulse = '0;
    endtask

    task automatic pulse(input logic [31:0] e);
        @(negedge clk);
        err_pulse = e;
        @(negedge clk);
        err_pulse = '0;
    endtask

    task automatic check_all(input string req, input logic [31:0] s, input logic [31:0] f,
                             input logic [31:0] n, input logic g);
        logic [31:0] d;
        rd(2'd0, d); check({req, " status"}, d, s);
        rd(2'd2, d); check({req, " first"}, d, f);
        rd(2'd3, d); check({req, " next"}, d, n);
        check({req, " global"}, {31'd0, global_err}, {31'd0, g});
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, keep_status;
        repeat (3) @(negedge clk);
        cold_rst_n = 1'b1;

        // R1 reset state
        check_all("R1", 32'h0, 32'h0, 32'h0, 1'b0);
        rd(2'd1, d); check("R1 mask", d, 32'h0000_E000);

        // R2 R6 R8 R9 R10 vector walk
        for (int i = 0; i < 7; i++) begin
            pulse(TBL[i][127:96]);
            check_all("R2/R6/R9 table", TBL[i][95:64], TBL[i][63:32], TBL[i][31:0], 1'b1);
        end

        // R3 write-1 clears, write-0 keeps
        wr_ev(2'd0, 32'h0000_0002, 32'h0);
        rd(2'd0, d); check("R3 clear", d, 32'h0000_F021);
        wr_ev(2'd0, 32'h0000_0000, 32'h0);
        rd(2'd0, d); check("R3 zero write", d, 32'h0000_F021);

        // R4 collision on status and next
        wr_ev(2'd0, 32'h0000_0001, 32'h0000_0001);
        rd(2'd0, d); check("R4 status", d, 32'h0000_F021);
        wr_ev(2'd3, 32'h0000_0001, 32'h0000_0001);
        rd(2'd3, d); check("R4 next", d, 32'h0000_1021);

        // R9 next clear; R10 global drops on first clear
        wr_ev(2'd3, 32'hFFFF_FFFF, 32'h0);
        rd(2'd3, d); check("R9 next clear", d, 32'h0);
        check("R10 still held", {31'd0, global_err}, 32'd1);
        wr_ev(2'd2, 32'h0000_0002, 32'h0);
        check_all("R10 released", 32'h0000_F021, 32'h0, 32'h0, 1'b0);

        // R5 reserved mask half
        wr_ev(2'd1, 32'hFFFF_FFFF, 32'h0);
        rd(2'd1, d); check("R5 mask", d, 32'h0000_FFFF);

        // R7 low nibble ignored, R6 bit 5 and 12 masked
        pulse(32'h0000_0004);
        check_all("R7 unmaskable", 32'h0000_F025, 32'h0000_0004, 32'h0, 1'b1);
        pulse(32'h0000_1020);
        check_all("R6 masked", 32'h0000_F025, 32'h0000_0004, 32'h0, 1'b1);
        pulse(32'h0000_0001);
        check_all("R7 into next", 32'h0000_F025, 32'h0000_0004, 32'h0000_0001, 1'b1);

        // R11 warm reset
        rd(2'd0, keep_status);
        @(negedge clk); warm_rst_n = 1'b0;
        @(negedge clk); @(negedge clk); warm_rst_n = 1'b1;
        check_all("R11", keep_status, 32'h0, 32'h0, 1'b0);
        rd(2'd1, d); check("R11 mask", d, 32'h0000_FFFF);

        // cold reset again, then R8 multi-bit capture and partial clear
        @(negedge clk); cold_rst_n = 1'b0;
        @(negedge clk); @(negedge clk); cold_rst_n = 1'b1;
        check_all("R1 again", 32'h0, 32'h0, 32'h0, 1'b0);
        rd(2'd1, d); check("R1 mask again", d, 32'h0000_E000);
        pulse(32'h0000_1006);
        check_all("R8 together", 32'h0000_1006, 32'h0000_1006, 32'h0, 1'b1);
        wr_ev(2'd2, 32'h0000_0002, 32'h0);
        check_all("R8 partial", 32'h0000_1006, 32'h0000_1004, 32'h0, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule